// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Unit

This block turns the current pixel (TMDS) clock frequency into the two audio clock regeneration numbers, N and CTS, that a downstream packet builder places in its regeneration packets. Software or a mode-setting controller presents the frequency in hertz on `pclk_hz` and pulses `pclk_load` for one cycle. A fixed 16-entry table is searched in ascending frequency order. The first entry whose frequency is greater than or equal to the requested clock is selected.

A hit starts a six-step write sequence into byte-wide staging registers. The upper CTS byte goes first. It carries CTS bits 19:16, a manual-CTS flag and an N-shift code. The middle and low CTS bytes follow, then the upper, middle and low N bytes. The final write commits every staged field to the outputs in one cycle, so the outputs never show a half-updated pair. A request above the top table frequency marks audio as unsupported and leaves the committed values alone. The audio input clock ratio is constant at 128 times the sample rate.

Top module: `acr_param_unit`

## Requirements
- R1: After synchronous reset `acr_valid`, `acr_busy`, `cts_manual` are 0 and `acr_n`, `acr_cts`, `n_shift` are all zero.
- R2: The selected entry is the lowest-frequency table entry whose frequency is at least `pclk_hz`. An exact match selects that entry, and a value one hertz above an entry selects the next one.
- R3: For the entries 25.175, 25.2, 27, 27.027, 40, 54, 54.054, 65, 74.25, 83.5, 106.5, 108 and 148.5 MHz, N is 6144 and CTS is the entry frequency in kHz.
- R4: The 74.176 MHz entry gives N=11648, CTS=140625. The 148.352 MHz entry gives N=5824, CTS=140625. The 297 MHz entry gives N=5120, CTS=247500.
- R5: A load with `pclk_hz` above 297,000,000 drives `acr_valid` low on the edge that samples it, raises no busy sequence, and leaves `acr_n`, `acr_cts`, `cts_manual` and `n_shift` unchanged.
- R6: On a hit, `acr_busy` is 1 after the sampling edge. `acr_n`, `acr_cts` and `acr_valid` keep their previous values through the next five edges, and all three take their new values together on the sixth edge after the sampling edge, when `acr_busy` returns to 0.
- R7: The write order is fixed: CTS upper, CTS middle, CTS low, N upper, N middle, N low. Only the N-low write commits. The CTS upper byte is {n_shift[2:0]=3'b001, manual=1, CTS[19:16]}, so after any commit `cts_manual`=1 and `n_shift`=3'b001.
- R8: `fs_ratio` always reads 128.
- R9: A `pclk_load` pulse while `acr_busy` is 1 is ignored, and the sequence in progress commits its original values.
- R10: `pclk_hz` = 0 selects the first entry (25.175 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_hz | input | 32 | Pixel clock frequency in Hz |
| pclk_load | input | 1 | One-cycle strobe that requests a new lookup |
| acr_n | output | 20 | Committed N value |
| acr_cts | output | 20 | Committed CTS value |
| acr_valid | output | 1 | Audio supported for the last committed or rejected request |
| acr_busy | output | 1 | Staging write sequence in progress |
| cts_manual | output | 1 | Committed manual-CTS flag |
| n_shift | output | 3 | Committed N-shift code |
| fs_ratio | output | 8 | Audio input clock ratio (constant 128) |

## Verification
A rejected request shows on `acr_valid` one edge after the sampling edge. A hit shows `acr_busy` on that same edge, then holds the old N, CTS and valid for five more edges, and presents the new values on the sixth. The bench drives `pclk_load` on a falling edge and counts falling edges from the sampling rising edge. It checks for a stable old pair after the third edge and for the new pair just after the sixth, so a design that commits early or late fails one of the two samples. Every table frequency is swept at minus one, exact and plus one hertz, and each expected result is computed in the bench from the frequency list and the N/CTS rules.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int ACR_ENTRIES = 16;
    localparam int ACR_IDX_W   = $clog2(ACR_ENTRIES);
    localparam int ACR_VAL_W   = 20;
    localparam int ACR_FREQ_W  = 32;
    localparam int ACR_BYTE_W  = 8;
    localparam int ACR_TOP_W   = ACR_VAL_W - 2 * ACR_BYTE_W;
    localparam int ACR_N_STD   = 6144;
    localparam logic [2:0] ACR_SHIFT_CODE = 3'b001;
    localparam logic [7:0] ACR_FS_RATIO   = 8'd128;

    typedef struct packed {
        logic [ACR_FREQ_W-1:0] freq_hz;
        logic [ACR_VAL_W-1:0]  n;
        logic [ACR_VAL_W-1:0]  cts;
    } acr_entry_t;

    typedef enum logic [2:0] {
        WS_IDLE    = 3'd0,
        WS_CTS_HI  = 3'd1,
        WS_CTS_MID = 3'd2,
        WS_CTS_LO  = 3'd3,
        WS_N_HI    = 3'd4,
        WS_N_MID   = 3'd5,
        WS_N_LO    = 3'd6
    } wr_sel_t;

    function automatic acr_entry_t std_entry(input int unsigned khz);
        acr_entry_t e;
        e.freq_hz = ACR_FREQ_W'(khz * 1000);
        e.n       = ACR_VAL_W'(ACR_N_STD);
        e.cts     = ACR_VAL_W'(khz);
        return e;
    endfunction

    function automatic acr_entry_t special_entry(input int unsigned khz,
                                                 input int unsigned n,
                                                 input int unsigned cts);
        acr_entry_t e;
        e.freq_hz = ACR_FREQ_W'(khz * 1000);
        e.n       = ACR_VAL_W'(n);
        e.cts     = ACR_VAL_W'(cts);
        return e;
    endfunction

    function automatic acr_entry_t acr_table(input int unsigned idx);
        case (idx)
            0:       return std_entry(25175);
            1:       return std_entry(25200);
            2:       return std_entry(27000);
            3:       return std_entry(27027);
            4:       return std_entry(40000);
            5:       return std_entry(54000);
            6:       return std_entry(54054);
            7:       return std_entry(65000);
            8:       return special_entry(74176, 11648, 140625);
            9:       return std_entry(74250);
            10:      return std_entry(83500);
            11:      return std_entry(106500);
            12:      return std_entry(108000);
            13:      return special_entry(148352, 5824, 140625);
            14:      return std_entry(148500);
            default: return special_entry(297000, 5120, 247500);
        endcase
    endfunction

endpackage

// File: rtl/acr_lookup.sv
module acr_lookup
    import acr_pkg::*;
#(
    parameter int ENTRIES = ACR_ENTRIES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ACR_FREQ_W-1:0] pclk_hz,
    output logic                  hit,
    output acr_entry_t            entry
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ge;
    logic [ENTRIES-1:0] first;
    logic [ENTRIES:0]   seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            acr_entry_t tab;
            assign tab      = acr_table(i);
            assign ge[i]    = (pclk_hz <= tab.freq_hz);
            assign first[i] = ge[i] & ~seen[i];
            assign seen[i+1] = seen[i] | ge[i];
        end
    endgenerate

    logic [IW-1:0] idx;
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (first[i]) idx = IW'(i);
        end
    end

    assign hit   = seen[ENTRIES];
    assign entry = acr_table(int'(idx));

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(first) && (hit == (first != '0))) else $error("AST_ONE_MATCH"); // R2

    AST_MATCH_BOUND: assert property (@(posedge clk) disable iff (rst)
        hit |-> (pclk_hz <= entry.freq_hz)) else $error("AST_MATCH_BOUND"); // R2

endmodule

// File: rtl/acr_write_seq.sv
module acr_write_seq
    import acr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  acr_entry_t            entry_in,
    output logic                  busy,
    output wr_sel_t               wr_sel,
    output logic [ACR_BYTE_W-1:0] wr_data
);
    wr_sel_t    state;
    acr_entry_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WS_IDLE;
            held  <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    state <= WS_CTS_HI;
                    held  <= entry_in;
                end
                WS_CTS_HI:  state <= WS_CTS_MID;
                WS_CTS_MID: state <= WS_CTS_LO;
                WS_CTS_LO:  state <= WS_N_HI;
                WS_N_HI:    state <= WS_N_MID;
                WS_N_MID:   state <= WS_N_LO;
                default:    state <= WS_IDLE;
            endcase
        end
    end

    assign busy   = (state != WS_IDLE);
    assign wr_sel = state;

    always_comb begin
        case (state)
            WS_CTS_HI:  wr_data = {ACR_SHIFT_CODE, 1'b1, held.cts[ACR_VAL_W-1 -: ACR_TOP_W]};
            WS_CTS_MID: wr_data = held.cts[2*ACR_BYTE_W-1 -: ACR_BYTE_W];
            WS_CTS_LO:  wr_data = held.cts[ACR_BYTE_W-1:0];
            WS_N_HI:    wr_data = {{(ACR_BYTE_W-ACR_TOP_W){1'b0}}, held.n[ACR_VAL_W-1 -: ACR_TOP_W]};
            WS_N_MID:   wr_data = held.n[2*ACR_BYTE_W-1 -: ACR_BYTE_W];
            WS_N_LO:    wr_data = held.n[ACR_BYTE_W-1:0];
            default:    wr_data = '0;
        endcase
    end

    AST_CTS_HI_LEADS: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == WS_CTS_HI) |-> ($past(wr_sel) == WS_IDLE)) else $error("AST_CTS_HI_LEADS"); // R7

    AST_N_LO_LAST: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == WS_N_LO) |=> (wr_sel == WS_IDLE)) else $error("AST_N_LO_LAST"); // R7

    AST_HOLD_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_sel != WS_N_LO) |=> $stable(held)) else $error("AST_HOLD_IN_FLIGHT"); // R9

endmodule

// File: rtl/acr_shadow_bank.sv
module acr_shadow_bank
    import acr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  wr_sel_t               wr_sel,
    input  logic [ACR_BYTE_W-1:0] wr_data,
    input  logic                  reject,
    output logic [ACR_VAL_W-1:0]  n_out,
    output logic [ACR_VAL_W-1:0]  cts_out,
    output logic                  valid_out,
    output logic                  manual_out,
    output logic [2:0]            shift_out
);
    logic [ACR_BYTE_W-1:0] stg_cts_hi, stg_cts_mid, stg_cts_lo;
    logic [ACR_BYTE_W-1:0] stg_n_hi, stg_n_mid;
    logic                  commit;

    assign commit = (wr_sel == WS_N_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cts_hi  <= '0;
            stg_cts_mid <= '0;
            stg_cts_lo  <= '0;
            stg_n_hi    <= '0;
            stg_n_mid   <= '0;
            n_out       <= '0;
            cts_out     <= '0;
            valid_out   <= 1'b0;
            manual_out  <= 1'b0;
            shift_out   <= '0;
        end else begin
            case (wr_sel)
                WS_CTS_HI:  stg_cts_hi  <= wr_data;
                WS_CTS_MID: stg_cts_mid <= wr_data;
                WS_CTS_LO:  stg_cts_lo  <= wr_data;
                WS_N_HI:    stg_n_hi    <= wr_data;
                WS_N_MID:   stg_n_mid   <= wr_data;
                default: ;
            endcase
            if (commit) begin
                n_out      <= {stg_n_hi[ACR_TOP_W-1:0], stg_n_mid, wr_data};
                cts_out    <= {stg_cts_hi[ACR_TOP_W-1:0], stg_cts_mid, stg_cts_lo};
                manual_out <= stg_cts_hi[ACR_TOP_W];
                shift_out  <= stg_cts_hi[ACR_BYTE_W-1 -: 3];
                valid_out  <= 1'b1;
            end else if (reject) begin
                valid_out  <= 1'b0;
            end
        end
    end

    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(n_out) && $stable(cts_out))) else $error("AST_NO_PARTIAL"); // R6

    AST_FLAGS_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> (manual_out && shift_out == ACR_SHIFT_CODE && valid_out)) else $error("AST_FLAGS_ON_COMMIT"); // R7

endmodule

// File: rtl/acr_param_unit.sv
module acr_param_unit
    import acr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pclk_hz,
    input  logic        pclk_load,
    output logic [19:0] acr_n,
    output logic [19:0] acr_cts,
    output logic        acr_valid,
    output logic        acr_busy,
    output logic        cts_manual,
    output logic [2:0]  n_shift,
    output logic [7:0]  fs_ratio
);
    logic                  hit;
    acr_entry_t            entry;
    logic                  start;
    logic                  reject;
    wr_sel_t               wr_sel;
    logic [ACR_BYTE_W-1:0] wr_data;

    acr_lookup #(.ENTRIES(ACR_ENTRIES)) u_lookup (
        .clk     (clk),
        .rst     (rst),
        .pclk_hz (pclk_hz),
        .hit     (hit),
        .entry   (entry)
    );

    assign start  = pclk_load & ~acr_busy & hit;
    assign reject = pclk_load & ~acr_busy & ~hit;

    acr_write_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .entry_in (entry),
        .busy     (acr_busy),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data)
    );

    acr_shadow_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .reject     (reject),
        .n_out      (acr_n),
        .cts_out    (acr_cts),
        .valid_out  (acr_valid),
        .manual_out (cts_manual),
        .shift_out  (n_shift)
    );

    assign fs_ratio = ACR_FS_RATIO;

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (pclk_load && !acr_busy && !hit) |=> (!acr_valid && !acr_busy && $stable(acr_n) && $stable(acr_cts))) else $error("AST_MISS_CLEARS"); // R5

    AST_HIT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (pclk_load && !acr_busy && hit) |=> acr_busy) else $error("AST_HIT_STARTS"); // R6

endmodule

// File: tb/tb_acr_param_unit.sv
module tb_acr_param_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pclk_hz;
    logic        pclk_load;
    logic [19:0] acr_n, acr_cts;
    logic        acr_valid, acr_busy, cts_manual;
    logic [2:0]  n_shift;
    logic [7:0]  fs_ratio;

    int compared   = 0;
    int mismatched = 0;

    logic [19:0] exp_n   = '0;
    logic [19:0] exp_cts = '0;
    logic        exp_v   = 1'b0;
    logic        exp_man = 1'b0;
    logic [2:0]  exp_sh  = '0;

    always #10 clk = ~clk;

    acr_param_unit dut (
        .clk(clk), .rst(rst), .pclk_hz(pclk_hz), .pclk_load(pclk_load),
        .acr_n(acr_n), .acr_cts(acr_cts), .acr_valid(acr_valid),
        .acr_busy(acr_busy), .cts_manual(cts_manual), .n_shift(n_shift),
        .fs_ratio(fs_ratio)
    );

    function automatic longint khz_of(input int i);
        case (i)
            0: return 25175;   1: return 25200;   2: return 27000;   3: return 27027;
            4: return 40000;   5: return 54000;   6: return 54054;   7: return 65000;
            8: return 74176;   9: return 74250;  10: return 83500;  11: return 106500;
            12: return 108000; 13: return 148352; 14: return 148500; default: return 297000;
        endcase
    endfunction

    function automatic int pick(input longint p);
        for (int i = 0; i < 16; i++) if (p <= khz_of(i) * 1000) return i;
        return -1;
    endfunction

    function automatic longint n_of(input longint k);
        if (k == 74176) return 11648;
        if (k == 148352) return 5824;
        if (k == 297000) return 5120;
        return 6144;
    endfunction

    function automatic longint cts_of(input longint k);
        if (k == 74176 || k == 148352) return 140625;
        if (k == 297000) return 247500;
        return k;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_held(input string tag);
        chk({tag, " n"}, acr_n, exp_n);
        chk({tag, " cts"}, acr_cts, exp_cts);
        chk({tag, " valid"}, acr_valid, exp_v);
        chk({tag, " manual"}, cts_manual, exp_man);
        chk({tag, " shift"}, n_shift, exp_sh);
    endtask

    // Drive a load; checks R2..R7 with the edge counting from the sampling edge.
    task automatic apply(input longint p, input bool_interfere);
        int idx;
        idx = pick(p);
        @(negedge clk);
        pclk_hz   = p[31:0];
        pclk_load = 1'b1;
        @(negedge clk);              // sampling edge E0 has passed
        pclk_load = 1'b0;
        if (idx < 0) begin
            exp_v = 1'b0;
            chk("R5 busy", acr_busy, 0);
            check_held("R5 miss");
        end else begin
            chk("R6 busy after E0", acr_busy, 1);
            check_held("R6 held E0");
            @(negedge clk);          // after E1
            @(negedge clk);          // after E2
            if (bool_interfere) begin
                pclk_hz   = 32'hFFFF_FFFF;
                pclk_load = 1'b1;    // R9: ignored while busy
            end
            @(negedge clk);          // after E3
            pclk_load = 1'b0;
            check_held("R6 held E3");
            @(negedge clk);          // after E4
            @(negedge clk);          // after E5
            chk("R6 busy E5", acr_busy, 1);
            check_held("R6 held E5");
            @(negedge clk);          // after E6: commit
            exp_n   = 20'(n_of(khz_of(idx)));
            exp_cts = 20'(cts_of(khz_of(idx)));
            exp_v   = 1'b1;
            exp_man = 1'b1;
            exp_sh  = 3'b001;
            chk("R6 busy done", acr_busy, 0);
            check_held((idx == 8 || idx == 13 || idx == 15) ? "R4 R2 R7 commit" : "R3 R2 R7 commit");
        end
    endtask

    initial begin
        #(20 * 150000);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pclk_hz = '0;
        pclk_load = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", acr_busy, 0);
        check_held("R1 reset");
        chk("R8 ratio", fs_ratio, 128);

        apply(0, 1'b0);                                   // R10
        chk("R10 zero picks first cts", acr_cts, 25175);

        apply(400_000_000, 1'b0);                         // R5 above max
        chk("R5 valid low", acr_valid, 0);

        for (int i = 0; i < 16; i++) begin
            longint f;
            f = khz_of(i) * 1000;
            apply(f - 1, 1'b0);
            apply(f, 1'b0);
            apply(f + 1, 1'b0);
        end

        apply(297_000_000, 1'b0);
        apply(32'hFFFF_FFFF, 1'b0);                       // R5 max input
        chk("R5 n kept", acr_n, 5120);

        apply(74_176_000, 1'b1);                          // R9 interference
        chk("R9 n kept from first load", acr_n, 11648);
        chk("R9 valid", acr_valid, 1);
        chk("R8 ratio end", fs_ratio, 128);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule